// File: doc/BRIEF.md
# Two-Channel Audio Peak Level Detector

The block watches a stream of signed audio samples, each carrying a channel tag and a valid strobe, and holds the largest absolute amplitude seen on the left channel and on the right channel. There is no time window. A held peak only grows until a host has shifted out the full peak word through a serial status readout. The readout logic raises a read-complete strobe at that point, and the strobe clears both peaks.

Samples come from one of two sources, picked by a select input. One source is the stream before level scaling and the other is the stream after level scaling. The peaks are always presented as a 32-bit word in transmit order, so a serial shifter can send it starting at bit 0.

Top module: `peak_level_det`

## Requirements
- R1: After reset the peak word shows both magnitudes as zero, with only the two channel identification bits set to their fixed values.
- R2: A valid sample whose stored magnitude is larger than the held peak of its channel replaces that peak. A sample whose stored magnitude is smaller or equal leaves the peak unchanged.
- R3: The magnitude of a negative sample is its absolute value, so a negative sample and the positive sample of the same size give the same peak.
- R4: The most negative input code is saturated to the largest positive magnitude, which makes the stored field all ones.
- R5: The stored value is the top PEAK_W bits of the (DATA_W-1)-bit magnitude. Lower bits are dropped, so a magnitude below 2^(DATA_W-1-PEAK_W) stores zero.
- R6: A pulse on rd_done_i clears both held peaks to zero on the next clock edge.
- R7: If a valid sample arrives in the same cycle as rd_done_i, the peak of its channel restarts from that sample's magnitude and not from zero. The other channel clears.
- R8: When src_sel_i is 0 the pre-scaling stream is used, and when it is 1 the post-scaling stream is used. The stream that is not selected has no effect on the peaks.
- R9: Word layout, with bit 0 sent first: bit 0 is 0 (left identification), bits PEAK_W..1 hold the left peak with its LSB in bit 1, bit PEAK_W+1 is 1 (right identification), and the bits above that hold the right peak with its LSB lowest.
- R10: A channel tag of 0 selects left and 1 selects right. A sample never changes the peak of the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_sel_i | input | 1 | Source select: 0 pre-scaling, 1 post-scaling |
| pre_vld_i | input | 1 | Pre-scaling sample valid |
| pre_chan_i | input | 1 | Pre-scaling channel tag (0 left, 1 right) |
| pre_data_i | input | DATA_W (18) | Pre-scaling sample, two's complement |
| post_vld_i | input | 1 | Post-scaling sample valid |
| post_chan_i | input | 1 | Post-scaling channel tag |
| post_data_i | input | DATA_W (18) | Post-scaling sample, two's complement |
| rd_done_i | input | 1 | Read-complete strobe from the status readout |
| peak_word_o | output | 2*(PEAK_W+1) (32) | Formatted peak word, bit 0 sent first |

## Verification
The bench builds the block with DATA_W=8 and PEAK_W=5, so the magnitude is 7 bits and the stored field is its top 5 bits. With these widths the most negative code (-128), the saturated all-ones field, and values small enough to truncate to zero can all be written as short literal samples. The byte-wide samples also make the arrival of a sample in the same cycle as the clear, and traffic on the unselected source, easy to set up and to predict by hand.

// File: rtl/peak_pkg.sv
package peak_pkg;
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/peak_mag.sv
module peak_mag #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned PEAK_W = 15
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [PEAK_W-1:0] peak_o
);
  localparam int unsigned MAG_W = DATA_W - 1;

  logic [DATA_W-1:0] neg_w;
  logic              is_min;
  logic [MAG_W-1:0]  mag_w;
  logic              unused_mag;

  assign neg_w  = (~data_i) + 1'b1;
  assign is_min = (data_i == {1'b1, {MAG_W{1'b0}}});

  always_comb begin
    if (is_min)               mag_w = {MAG_W{1'b1}};
    else if (data_i[MAG_W])   mag_w = neg_w[MAG_W-1:0];
    else                      mag_w = data_i[MAG_W-1:0];
  end

  // keep upper PEAK_W bits of the magnitude
  assign peak_o     = mag_w[MAG_W-1 -: PEAK_W];
  assign unused_mag = &{1'b0, mag_w, neg_w[MAG_W]};

  initial begin
    assert (PEAK_W < MAG_W) else $error("PEAK_W must be below DATA_W-1");
  end
endmodule

// File: rtl/peak_hold.sv
module peak_hold #(
  parameter int unsigned PEAK_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [PEAK_W-1:0] sample_i,
  input  logic              clr_i,
  output logic [PEAK_W-1:0] peak_o
);
  logic [PEAK_W-1:0] peak_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peak_q <= '0;
    end else if (clr_i) begin
      // restart from a coincident sample so it is not lost
      peak_q <= hit_i ? sample_i : '0;
    end else if (hit_i && (sample_i > peak_q)) begin
      peak_q <= sample_i;
    end
  end

  assign peak_o = peak_q;

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit_i) |=> (peak_o == '0));

  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && hit_i) |=> (peak_o == $past(sample_i)));

  assert_grow_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (peak_o >= $past(peak_o)));

  assert_no_touch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !hit_i) |=> $stable(peak_o));

  assert_reaches_max_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && hit_i) |=> (peak_o >= $past(sample_i)));
endmodule

// File: rtl/peak_level_det.sv
module peak_level_det
  import peak_pkg::*;
#(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned PEAK_W = 15,
  localparam int unsigned FLD_W  = PEAK_W + 1,
  localparam int unsigned WORD_W = NUM_CH * FLD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_sel_i,
  input  logic              pre_vld_i,
  input  logic              pre_chan_i,
  input  logic [DATA_W-1:0] pre_data_i,
  input  logic              post_vld_i,
  input  logic              post_chan_i,
  input  logic [DATA_W-1:0] post_data_i,
  input  logic              rd_done_i,
  output logic [WORD_W-1:0] peak_word_o
);
  logic              vld;
  logic              chan;
  logic [DATA_W-1:0] data;
  logic [PEAK_W-1:0] sample;

  assign vld  = src_sel_i ? post_vld_i  : pre_vld_i;
  assign chan = src_sel_i ? post_chan_i : pre_chan_i;
  assign data = src_sel_i ? post_data_i : pre_data_i;

  peak_mag #(.DATA_W(DATA_W), .PEAK_W(PEAK_W)) u_mag (
    .data_i (data),
    .peak_o (sample)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [PEAK_W-1:0] peak;
    logic              hit;
    assign hit = vld && (chan == c[0]);

    peak_hold #(.PEAK_W(PEAK_W)) u_hold (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hit_i    (hit),
      .sample_i (sample),
      .clr_i    (rd_done_i),
      .peak_o   (peak)
    );

    // id bit first, magnitude LSB next
    assign peak_word_o[c*FLD_W]                 = c[0];
    assign peak_word_o[c*FLD_W+1 +: PEAK_W]     = peak;
  end

  assert_src_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_done_i && !(src_sel_i ? post_vld_i : pre_vld_i)) |=> $stable(peak_word_o));

  assert_clear_word_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_done_i && !vld) |=> (peak_word_o == WORD_W'({1'b1, {FLD_W{1'b0}}})));
endmodule

// File: tb/peak_level_det_tb.sv
`timescale 1ns/1ps
module peak_level_det_tb;
  localparam int unsigned DW = 8;
  localparam int unsigned PW = 5;
  localparam int unsigned WW = 2 * (PW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          src_sel = 1'b0;
  logic          pre_vld = 1'b0, pre_chan = 1'b0;
  logic [DW-1:0] pre_data = '0;
  logic          post_vld = 1'b0, post_chan = 1'b0;
  logic [DW-1:0] post_data = '0;
  logic          rd_done = 1'b0;
  logic [WW-1:0] word;

  always #2 clk = ~clk;

  peak_level_det #(.DATA_W(DW), .PEAK_W(PW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_sel_i(src_sel),
    .pre_vld_i(pre_vld), .pre_chan_i(pre_chan), .pre_data_i(pre_data),
    .post_vld_i(post_vld), .post_chan_i(post_chan), .post_data_i(post_data),
    .rd_done_i(rd_done), .peak_word_o(word)
  );

  int checks = 0;
  int errors = 0;
  logic [WW-1:0] exp_q[$];
  string         tag_q[$];
  logic [PW-1:0] m_left = '0, m_right = '0;

  function automatic logic [PW-1:0] ref_mag(input int v);
    int a;
    a = (v < 0) ? -v : v;
    if (a > 127) a = 127;
    return PW'(a / 4);
  endfunction

  function automatic logic [WW-1:0] fmt(input logic [PW-1:0] l, input logic [PW-1:0] r);
    return {r, 1'b1, l, 1'b0};
  endfunction

  // one cycle of stimulus; expected word queued for the monitor
  task automatic step(input string tag, input logic sel,
                      input logic pv, input logic pc, input int pd,
                      input logic qv, input logic qc, input int qd,
                      input logic rd);
    logic sv, sc;
    logic [PW-1:0] m;
    @(negedge clk);
    src_sel = sel; pre_vld = pv; pre_chan = pc; pre_data = DW'(pd);
    post_vld = qv; post_chan = qc; post_data = DW'(qd); rd_done = rd;
    sv = sel ? qv : pv; sc = sel ? qc : pc;
    m  = ref_mag(sel ? qd : pd);
    if (rd) begin
      m_left  = (sv && !sc) ? m : '0;
      m_right = (sv &&  sc) ? m : '0;
    end else if (sv) begin
      if (!sc && m > m_left)  m_left  = m;
      if ( sc && m > m_right) m_right = m;
    end
    @(negedge clk);
    pre_vld = 1'b0; post_vld = 1'b0; rd_done = 1'b0;
    exp_q.push_back(fmt(m_left, m_right));
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk); #1;
      while (exp_q.size() > 0) begin
        logic [WW-1:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        checks++;
        if (word !== e) begin
          errors++;
          $display("FAIL %s: got %b expected %b", t, word, e);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    checks++;
    if (word !== fmt('0, '0)) begin
      errors++; $display("FAIL R1: got %b expected %b", word, fmt('0, '0));
    end
    rst_n = 1'b1;
    step("R1_idle", 0, 0,0,0, 0,0,0, 0);
    step("R2_left_rise", 0, 1,0,40, 0,0,0, 0);          // 10
    step("R2_left_smaller", 0, 1,0,20, 0,0,0, 0);
    step("R10_right_only", 0, 1,1,-100, 0,0,0, 0);      // right 25
    step("R3_negative", 0, 1,0,-44, 0,0,0, 0);          // 11
    step("R4_most_neg", 0, 1,0,-128, 0,0,0, 0);         // 31
    step("R8_unselected_post", 0, 0,0,0, 1,1,127, 0);
    step("R6_clear", 0, 0,0,0, 0,0,0, 1);
    step("R5_truncate_zero", 0, 1,0,3, 0,0,0, 0);       // 0
    step("R5_truncate_one", 0, 1,1,-4, 0,0,0, 0);       // right 1
    step("R7_restart", 0, 1,0,60, 0,0,0, 1);            // left 15, right 0
    step("R8_post_selected", 1, 1,1,127, 1,1,80, 0);    // right 20
    step("R8_unselected_pre", 1, 1,0,127, 0,0,0, 0);
    step("R9_format_full", 1, 0,0,0, 1,1,127, 0);       // right 31
    step("R7_restart_right", 1, 0,0,0, 1,1,-8, 1);      // left 0, right 2
    step("R2_equal_hold", 1, 0,0,0, 1,1,9, 0);          // 9/4=2
    @(negedge clk); @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule